// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from twenty sources and chooses one to present to the CPU. The sources are two external request pins, timer capture, compare and overflow events, pulse-accumulator events, two serial completions, a periodic tick, a watchdog failure, a clock-monitor failure, a software-interrupt instruction and an illegal-opcode trap. Each request is latched on the clock and stays latched until the CPU acknowledges it.

Fifteen sources are maskable. Each has its own enable bit, and a global mask input blocks all fifteen together. The remaining five sources cannot be masked. Among the eligible latched requests, the one in the highest slot wins. The controller drives the address of that source's two-byte vector slot, together with a pending flag. The CPU reads the routine address from that slot and the following byte, and then pulses the acknowledge input. Stacking registers and fetching the routine address are done elsewhere.

Request bit i owns the slot at 0xFFD6 + 2*i. The slots climb from the serial-communication source at bit 0 to the clock monitor at bit 19, just below the reset word at 0xFFFE. Bits 15 to 19 are the five non-maskable sources:

| Bit | Source | Bit | Source | Bit | Source | Bit | Source |
|---|---|---|---|---|---|---|---|
| 0 | serial comms | 5 | timer overflow | 10 | output compare 1 | 15 | non-maskable pin |
| 1 | SPI done | 6 | output compare 5 | 11 | input capture 3 | 16 | software interrupt |
| 2 | pulse-acc edge | 7 | output compare 4 | 12 | input capture 2 | 17 | illegal opcode |
| 3 | pulse-acc overflow | 8 | output compare 3 | 13 | input capture 1 | 18 | watchdog failure |
| 4 | ... | 9 | output compare 2 | 14 | maskable pin | 19 | clock-monitor fail |

Bit 4 is the real-time tick.

Top module: `vec_int_ctrl`

## Requirements
- R1: While the pending flag is high, `vec_addr` equals 0xFFD6 + 2*w, where w is the index of the winning request bit. This places bit 19 at 0xFFFC and bit 0 at 0xFFD6.
- R2: When no latched request is eligible, `irq_pending` is 0 and `vec_addr` is 0x0000.
- R3: A request bit that is high at a rising clock edge is latched by that edge, and it shows at the outputs right after that edge. It stays latched after the input falls, until it is acknowledged.
- R4: When several eligible requests are latched, the one with the highest bit index wins.
- R5: A maskable request (bits 0 to 14) is eligible only while its bit in `src_en` is 1. Bit k of `src_en` belongs to request bit k.
- R6: While `gmask` is 1, no maskable request is eligible.
- R7: Requests in bits 15 to 19 are eligible whatever the values of `src_en` and `gmask`.
- R8: When `ack` is high at a clock edge while a request is pending, only the winning source's latch is cleared. All other latches keep their state.
- R9: An active-low synchronous reset clears every latch.
- R10: A latched request that is blocked by its enable bit or by `gmask` stays latched. It wins in the same cycle in which it becomes eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | 20 | Level request per source, bit index as in the table above |
| src_en | input | 15 | Enable bits for maskable sources 0 to 14 |
| gmask | input | 1 | Global mask for maskable sources |
| ack | input | 1 | Acknowledge of the presented source |
| irq_pending | output | 1 | An eligible request is latched |
| vec_addr | output | 16 | Address of the winner's vector slot, or 0 when none |

## Verification
The hardest case to reach from the ports is a latch that is held while blocked: a request must be latched, its level removed, and its enable or the global mask closed, before it is released again. The bench does this in sequence for every maskable source, with a single pulse followed by a change of enable. It also acknowledges every ordered pair of sources in turn, which shows that each acknowledge removes the winner and leaves the loser.

// File: rtl/vec_int_ctrl.sv
module vec_int_ctrl #(
  parameter int NSRC = 20,
  parameter int NNMI = 5,
  parameter int AW = 16,
  parameter logic [AW-1:0] TOP_SLOT = 16'hFFFC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-NNMI-1:0] src_en,
  input  logic            gmask,
  input  logic            ack,
  output logic            irq_pending,
  output logic [AW-1:0]   vec_addr
);
  localparam int NMASK = NSRC - NNMI;
  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] BASE = TOP_SLOT - AW'(2 * (NSRC - 1));

  logic [NSRC-1:0] pend, elig, clr;
  logic [IW-1:0] win;
  logic any;

  assign elig[NSRC-1:NMASK] = pend[NSRC-1:NMASK];
  assign elig[NMASK-1:0] = pend[NMASK-1:0] & src_en & {NMASK{~gmask}};

  always_comb begin
    win = '0;
    any = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (elig[i]) begin
        win = IW'(i);
        any = 1'b1;
      end
  end

  assign clr = (ack && any) ? (NSRC'(1) << win) : '0;

  always_ff @(posedge clk)
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | src_req;

  assign irq_pending = any;
  assign vec_addr = any ? BASE + AW'({win, 1'b0}) : '0;

  assert_slot_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (vec_addr[0] == 1'b0 && vec_addr >= BASE && vec_addr <= TOP_SLOT));
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_pending |-> vec_addr == '0);
  assert_latch_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> ((pend & $past(pend)) == $past(pend)));
  assert_gmask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && !(|pend[NSRC-1:NMASK])) |-> !irq_pending);
  assert_nmi_forwarded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend[NSRC-1:NMASK]) |-> irq_pending);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && any && !src_req[win]) |=> !pend[$past(win)]);
endmodule

// File: tb/vec_int_ctrl_test.sv
module vec_int_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 20;
  localparam int NMASK = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_req = '0;
  logic [NMASK-1:0] src_en = '1;
  logic gmask = 1'b0;
  logic ack = 1'b0;
  logic irq_pending;
  logic [15:0] vec_addr;
  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_int_ctrl uut (.clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
                    .gmask(gmask), .ack(ack), .irq_pending(irq_pending), .vec_addr(vec_addr));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ev, input int idx, input string req);
    logic [15:0] ea;
    ea = ev ? 16'(16'hFFD6 + 2 * idx) : 16'h0000;
    checks++;
    if (irq_pending !== ev || vec_addr !== ea) begin
      fails++;
      $display("FAIL %s: pending=%0b vec=%h expected pending=%0b vec=%h", req, irq_pending, vec_addr, ev, ea);
    end
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); src_req = NSRC'(1) << idx;
    tick();
    @(negedge clk); src_req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    tick();
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; src_req = '0; src_en = '1; gmask = 1'b0; ack = 1'b0;
    tick();
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(0, 0, "R9 reset state");
    @(negedge clk); rst_n = 1'b1;
    tick();
    chk(0, 0, "R2 idle");

    for (int i = 0; i < NSRC; i++) begin
      do_reset();
      @(negedge clk); src_req = NSRC'(1) << i;
      tick();
      chk(1, i, "R1 R3 latched slot");
      @(negedge clk); src_req = '0;
      tick(); tick();
      chk(1, i, "R3 held after fall");
      do_ack();
      #1 chk(0, 0, "R8 ack clears");
    end

    for (int i = 0; i < NSRC; i++)
      for (int j = i + 1; j < NSRC; j++) begin
        do_reset();
        @(negedge clk); src_req = (NSRC'(1) << i) | (NSRC'(1) << j);
        tick();
        @(negedge clk); src_req = '0;
        #1 chk(1, j, "R4 highest wins");
        do_ack();
        #1 chk(1, i, "R8 other stays");
        do_ack();
        #1 chk(0, 0, "R8 all cleared");
      end

    for (int i = 0; i < NMASK; i++) begin
      do_reset();
      @(negedge clk); src_en = '1; src_en[i] = 1'b0;
      pulse(i);
      #1 chk(0, 0, "R5 disabled blocked");
      @(negedge clk); ack = 1'b1;
      tick();
      @(negedge clk); ack = 1'b0; src_en[i] = 1'b1;
      #1 chk(1, i, "R10 enable releases");
      @(negedge clk); gmask = 1'b1;
      #1 chk(0, 0, "R6 gmask blocks");
      @(negedge clk); gmask = 1'b0;
      #1 chk(1, i, "R10 unmask releases");
    end

    for (int i = NMASK; i < NSRC; i++) begin
      do_reset();
      @(negedge clk); src_en = '0; gmask = 1'b1;
      pulse(i);
      #1 chk(1, i, "R7 non-maskable forwarded");
      @(negedge clk); src_req = NSRC'(1) << (i - NMASK); src_en = '1;
      tick();
      @(negedge clk); src_req = '0;
      #1 chk(1, i, "R7 masked lower below");
      do_ack();
      #1 chk(0, 0, "R6 lower held masked");
      @(negedge clk); gmask = 1'b0;
      #1 chk(1, i - NMASK, "R10 lower released");
    end

    do_reset();
    @(negedge clk); src_req = '1;
    tick();
    @(negedge clk); src_req = '0; rst_n = 1'b0;
    tick();
    @(negedge clk); rst_n = 1'b1;
    #1 chk(0, 0, "R9 reset clears all");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule